// File: doc/BRIEF.md
# LED Driver Fault Protection Manager

This block gathers the digital fault flags of a switching LED driver and decides whether the power switch may be driven. It qualifies two flags over time. A severe over-current flag only counts on switching-cycle strobes, and it must appear on several strobes in a row. A zero-crossing-low flag must stay low for a programmable number of clock cycles. Three level flags act at once: supply over-voltage, thermal shutdown and pin over-voltage. The block then either blocks the drive for a fixed restart delay or latches it off.

A mode strap chooses latch-off or timed auto-recovery for every fault class except supply over-voltage, which always auto-recovers. The strap is sampled when a fault is taken. A supply-reset flag, raised when the supply collapses, clears every fault and all counting state. The first fault taken is reported as a 3-bit code until the drive is enabled again.

Top module: `led_fault_guard`

## Requirements
- R1: After reset the drive enable is 1 and the fault code is 0.
- R2: Fault code 1 (winding/diode short) is taken when the severe over-current flag is set on OCP_RUN consecutive cycle strobes. A strobe without the flag restarts the count. Clock cycles without a strobe leave the count unchanged. The count restarts from zero after every recovery.
- R3: Fault code 2 (output short) is taken when the zero-crossing-low flag has been high for ZLOW_TICKS consecutive clock cycles. A shorter low period has no effect.
- R4: Fault code 3 (supply over-voltage) is taken on the first cycle the flag is high. It always uses auto-recovery, whatever the mode strap says.
- R5: Fault code 4 (thermal shutdown) and fault code 5 (pin over-voltage) are taken on the first cycle their flag is high.
- R6: When several faults arise in the same cycle, the lowest code wins. The code taken first is held and is not replaced by later faults.
- R7: With the strap at 0 (auto-recovery), the drive enable is 0 for exactly RETRY_TICKS cycles after the fault is taken. After that the drive enable returns to 1 and the code returns to 0.
- R8: If the supply over-voltage, thermal or pin over-voltage flag is high when the delay expires, a new delay of RETRY_TICKS starts and the code is kept.
- R9: With the strap at 1 (latch-off), codes 1, 2, 4 and 5 keep the drive enable at 0 until the supply-reset flag is raised.
- R10: A high supply-reset flag makes the drive enable 1 and the code 0 on the next cycle, from any state. It also clears both qualifying counters.
- R11: A change of the mode strap after a fault has been taken has no effect on that fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_strobe_i | input | 1 | One pulse per switching cycle |
| ocp_sev_i | input | 1 | Severe over-current flag, valid with the strobe |
| zcd_low_i | input | 1 | Zero-crossing input is low |
| vcc_ov_i | input | 1 | Supply over-voltage (open load) |
| therm_sd_i | input | 1 | Thermal shutdown level reached |
| pin_ov_i | input | 1 | Pin over-voltage |
| supply_rst_i | input | 1 | Supply below the reset level |
| latch_mode_i | input | 1 | 1 selects latch-off, 0 selects auto-recovery |
| drv_en_o | output | 1 | Gate drive allowed |
| fault_code_o | output | 3 | Active fault: 0 none, 1 to 5 as listed in the requirements |

## Verification
Two collisions matter in this block. The first is a fault flag raised in the same cycle as the supply-reset flag. The second is a restart delay expiring while a level fault is still present. The random phase provokes both by keeping the level flags and the supply-reset flag sparse and independent, and by holding the zero-crossing flag in long bursts. Directed sections add a thermal fault held across an expiry and two faults raised together. Every cycle, the drive enable and the fault code are compared against a bench model that applies the rule that supply reset dominates, the rule that the lowest code wins, and the restart-on-present rule at expiry.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_RETRY, ST_LATCH} fg_state_e;

  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned CODE_W  = $clog2(NUM_SRC + 1);

  localparam logic [CODE_W-1:0] FC_NONE  = 3'd0;
  localparam logic [CODE_W-1:0] FC_WIND  = 3'd1;
  localparam logic [CODE_W-1:0] FC_OUTS  = 3'd2;
  localparam logic [CODE_W-1:0] FC_VCCOV = 3'd3;
  localparam logic [CODE_W-1:0] FC_THERM = 3'd4;
  localparam logic [CODE_W-1:0] FC_PINOV = 3'd5;
endpackage

// File: rtl/fg_streak.sv
// Counts consecutive qualified hits; trips on the LIMIT-th one.
module fg_streak #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic hit_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign trip_o = en_i & hit_i & (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (en_i) begin
      if (!hit_i)             cnt_q <= '0;
      else if (cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP); // R2
  AST_MISS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !hit_i) |=> cnt_q == '0); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/fg_prio_enc.sv
// Lowest set request wins; code = index + 1, 0 when idle.
module fg_prio_enc
  import fault_guard_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic [N-1:0]      req_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/fg_restart_seq.sv
module fg_restart_seq
  import fault_guard_pkg::*;
#(
  parameter int unsigned RETRY_TICKS = 400_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] evt_code_i,
  input  logic              latch_mode_i,
  input  logic              hold_i,
  output logic              run_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned TW = $clog2(RETRY_TICKS + 1);
  localparam logic [TW-1:0] T_END = TW'(RETRY_TICKS - 1);

  fg_state_e         st_q;
  logic [CODE_W-1:0] code_q;
  logic [TW-1:0]     tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      code_q <= FC_NONE;
      tmr_q  <= '0;
    end else if (clr_i) begin
      st_q   <= ST_RUN;
      code_q <= FC_NONE;
      tmr_q  <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: if (evt_code_i != FC_NONE) begin
          code_q <= evt_code_i;
          tmr_q  <= '0;
          st_q   <= (latch_mode_i && evt_code_i != FC_VCCOV) ? ST_LATCH : ST_RETRY;
        end
        ST_RETRY: if (tmr_q == T_END) begin
          tmr_q <= '0;
          if (!hold_i) begin
            st_q   <= ST_RUN;
            code_q <= FC_NONE;
          end
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign run_o  = (st_q == ST_RUN);
  assign code_o = code_q;

  AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= T_END); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LATCH && !clr_i) |=> (st_q == ST_LATCH && $stable(code_q))); // R9
  AST_RETRY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RETRY && !clr_i && hold_i) |=> (st_q == ST_RETRY && $stable(code_q))); // R8
  AST_SUPPLY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (st_q == ST_RUN && code_q == FC_NONE)); // R10
  AST_VCC_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !clr_i && evt_code_i == FC_VCCOV) |=> st_q == ST_RETRY); // R4
endmodule

// File: rtl/led_fault_guard.sv
module led_fault_guard
  import fault_guard_pkg::*;
#(
  parameter int unsigned OCP_RUN     = 4,
  parameter int unsigned ZLOW_TICKS  = 9_000_000,
  parameter int unsigned RETRY_TICKS = 400_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cyc_strobe_i,
  input  logic       ocp_sev_i,
  input  logic       zcd_low_i,
  input  logic       vcc_ov_i,
  input  logic       therm_sd_i,
  input  logic       pin_ov_i,
  input  logic       supply_rst_i,
  input  logic       latch_mode_i,
  output logic       drv_en_o,
  output logic [2:0] fault_code_o
);
  logic               run;
  logic               cnt_clr;
  logic               wind_trip, outs_trip;
  logic [NUM_SRC-1:0] req;
  logic [CODE_W-1:0]  evt_code;

  assign cnt_clr = supply_rst_i | ~run;

  fg_streak #(.LIMIT(OCP_RUN)) u_wind (
    .clk_i, .rst_ni, .clr_i(cnt_clr),
    .en_i(cyc_strobe_i), .hit_i(ocp_sev_i), .trip_o(wind_trip)
  );

  fg_streak #(.LIMIT(ZLOW_TICKS)) u_outs (
    .clk_i, .rst_ni, .clr_i(cnt_clr),
    .en_i(1'b1), .hit_i(zcd_low_i), .trip_o(outs_trip)
  );

  // bit order sets priority: index 0 is code 1
  assign req = {pin_ov_i, therm_sd_i, vcc_ov_i, outs_trip, wind_trip};

  fg_prio_enc #(.N(NUM_SRC)) u_prio (.req_i(req), .code_o(evt_code));

  fg_restart_seq #(.RETRY_TICKS(RETRY_TICKS)) u_seq (
    .clk_i, .rst_ni, .clr_i(supply_rst_i),
    .evt_code_i(evt_code), .latch_mode_i,
    .hold_i(vcc_ov_i | therm_sd_i | pin_ov_i),
    .run_o(run), .code_o(fault_code_o)
  );

  assign drv_en_o = run;

  AST_WIND_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o && !supply_rst_i && wind_trip) |=> fault_code_o == FC_WIND); // R2
  AST_OUTS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o && !supply_rst_i && outs_trip && !wind_trip) |=> fault_code_o == FC_OUTS); // R3
  AST_LEVEL_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o && !supply_rst_i && (vcc_ov_i || therm_sd_i || pin_ov_i)) |=> !drv_en_o); // R5
  AST_EN_NO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> fault_code_o == FC_NONE); // R7
endmodule

// File: tb/led_fault_guard_bench.sv
module led_fault_guard_bench;
  localparam int unsigned OCP = 4;
  localparam int unsigned ZL  = 12;
  localparam int unsigned RT  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 0, ocp = 0, zlow = 0, vccov = 0, therm = 0, pinov = 0, srst = 0, lmode = 0;
  logic       drv_en;
  logic [2:0] code;

  int vectors = 0;
  int fails   = 0;

  // bench reference state
  int m_st   = 0;   // 0 run, 1 delay, 2 latched
  int m_code = 0;
  int m_ocp  = 0;
  int m_zl   = 0;
  int m_tmr  = 0;

  always #5 clk = ~clk;

  led_fault_guard #(.OCP_RUN(OCP), .ZLOW_TICKS(ZL), .RETRY_TICKS(RT)) u_led_fault_guard (
    .clk_i(clk), .rst_ni(rst_n), .cyc_strobe_i(strobe), .ocp_sev_i(ocp),
    .zcd_low_i(zlow), .vcc_ov_i(vccov), .therm_sd_i(therm), .pin_ov_i(pinov),
    .supply_rst_i(srst), .latch_mode_i(lmode),
    .drv_en_o(drv_en), .fault_code_o(code)
  );

  function automatic int pick_code(bit w, bit o, bit v, bit t, bit p);
    if (w) return 1;
    if (o) return 2;
    if (v) return 3;
    if (t) return 4;
    if (p) return 5;
    return 0;
  endfunction

  task automatic model_step();
    bit wt, ot;
    int c;
    if (srst) begin
      m_st = 0; m_code = 0; m_ocp = 0; m_zl = 0; m_tmr = 0;
    end else if (m_st == 0) begin
      wt = strobe && ocp && (m_ocp == OCP - 1);
      ot = zlow && (m_zl == ZL - 1);
      if (strobe) m_ocp = ocp ? ((m_ocp == OCP - 1) ? m_ocp : m_ocp + 1) : 0;
      m_zl = zlow ? ((m_zl == ZL - 1) ? m_zl : m_zl + 1) : 0;
      c = pick_code(wt, ot, vccov, therm, pinov);
      if (c != 0) begin
        m_code = c; m_tmr = 0; m_ocp = 0; m_zl = 0;
        m_st = (lmode && c != 3) ? 2 : 1;
      end
    end else if (m_st == 1) begin
      if (m_tmr == RT - 1) begin
        m_tmr = 0;
        if (!(vccov || therm || pinov)) begin m_st = 0; m_code = 0; end
      end else m_tmr++;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // advance one clock and compare against the model
  task automatic cyc(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({req, " drv"}, int'(drv_en), (m_st == 0) ? 1 : 0);
    chk({req, " code"}, int'(code), m_code);
  endtask

  task automatic idle_in();
    strobe = 0; ocp = 0; zlow = 0; vccov = 0; therm = 0; pinov = 0; srst = 0;
  endtask

  task automatic pulse_srst();
    idle_in(); srst = 1; cyc("R10 srst"); srst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 drv", int'(drv_en), 1);
    chk("R1 code", int'(code), 0);

    // R2: streak broken by a clean strobe, idle cycles neutral
    lmode = 0;
    for (int i = 0; i < 3; i++) begin
      strobe = 1; ocp = 1; cyc("R2 run");
      strobe = 0; ocp = 1; cyc("R2 idle");
    end
    strobe = 1; ocp = 0; cyc("R2 break");
    for (int i = 0; i < 3; i++) begin strobe = 1; ocp = 1; cyc("R2 run2"); end
    chk("R2 no trip", int'(drv_en), 1);
    strobe = 0; ocp = 1; cyc("R2 gap");
    strobe = 1; ocp = 1; cyc("R2 fourth");
    chk("R2 code", int'(code), 1);
    chk("R2 drv", int'(drv_en), 0);

    // R7: exact delay length
    idle_in();
    for (int i = 0; i < RT - 1; i++) cyc("R7 hold");
    chk("R7 still off", int'(drv_en), 0);
    cyc("R7 end");
    chk("R7 drv back", int'(drv_en), 1);
    chk("R7 code clr", int'(code), 0);

    // R2: count restarts after recovery
    for (int i = 0; i < 3; i++) begin strobe = 1; ocp = 1; cyc("R2 fresh"); end
    chk("R2 fresh count", int'(drv_en), 1);
    idle_in(); strobe = 1; cyc("R2 fresh clr");

    // R3: short low period, then full period, latch-off (R9)
    idle_in(); lmode = 1;
    zlow = 1;
    for (int i = 0; i < ZL - 1; i++) cyc("R3 short");
    zlow = 0; cyc("R3 release");
    chk("R3 short ignored", int'(drv_en), 1);
    zlow = 1;
    for (int i = 0; i < ZL; i++) cyc("R3 full");
    chk("R3 code", int'(code), 2);
    idle_in();
    lmode = 0;   // R11: strap change after fault taken
    for (int i = 0; i < 2 * RT; i++) cyc("R9 latched");
    chk("R9 still off", int'(drv_en), 0);
    chk("R11 code kept", int'(code), 2);
    pulse_srst();
    chk("R10 drv", int'(drv_en), 1);
    chk("R10 code", int'(code), 0);

    // R4: supply OV auto-recovers even with latch strap
    lmode = 1; vccov = 1; cyc("R4 take"); vccov = 0;
    chk("R4 code", int'(code), 3);
    for (int i = 0; i < RT; i++) cyc("R4 delay");
    chk("R4 recovered", int'(drv_en), 1);

    // R6 + R8: simultaneous thermal and pin OV, held across expiry
    lmode = 0; therm = 1; pinov = 1; cyc("R6 both");
    chk("R6 lowest wins", int'(code), 4);
    pinov = 0;
    for (int i = 0; i < RT + 5; i++) cyc("R8 held");
    chk("R8 restarted", int'(drv_en), 0);
    chk("R8 code kept", int'(code), 4);
    therm = 0;
    for (int i = 0; i < RT; i++) cyc("R8 second");
    chk("R8 recovered", int'(drv_en), 1);

    // R5: pin OV alone, latch-off
    lmode = 1; pinov = 1; cyc("R5 pin"); pinov = 0;
    chk("R5 code", int'(code), 5);
    strobe = 1; ocp = 1;
    for (int i = 0; i < 6; i++) cyc("R6 later fault");
    chk("R6 first kept", int'(code), 5);
    pulse_srst();

    // R10: supply reset clears a partial streak; also beats a fault
    for (int i = 0; i < 3; i++) begin strobe = 1; ocp = 1; cyc("R10 pre"); end
    pulse_srst();
    strobe = 1; ocp = 1; cyc("R10 after");
    chk("R10 streak cleared", int'(drv_en), 1);
    idle_in(); therm = 1; srst = 1; cyc("R10 dominates");
    chk("R10 dom drv", int'(drv_en), 1);
    idle_in(); cyc("R10 settle");
    pulse_srst();

    // random phase
    for (int n = 0; n < 6000; n++) begin
      strobe = ($urandom % 2) == 0;
      ocp    = ($urandom % 10) < 7;
      if (($urandom % 10) == 0) zlow = ~zlow;
      vccov  = ($urandom % 150) == 0;
      therm  = ($urandom % 150) == 0 ? 1'b1 : (therm && ($urandom % 4) != 0);
      pinov  = ($urandom % 200) == 0;
      srst   = ($urandom % 250) == 0;
      if (($urandom % 300) == 0) lmode = ~lmode;
      cyc("R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule